// File: doc/BRIEF.md
# Capacity Occupancy Counter Bank with Zero Floor

This block keeps one occupancy counter per monitoring identifier for a cache-like storage structure. Each cycle it may see an allocation strobe and a release strobe. Each strobe carries a monitoring identifier, an access type and a number of capacity units. An armed counter adds the units of allocations that match its filter and subtracts the units of matching releases. It never goes below zero and never goes above its largest value. The zero floor covers releases of capacity that was allocated before the counter was last cleared, for example after an identifier has been handed to a new workload.

Software drives the block through a command port. A command is an operation code, a target identifier, an event selector, an access-type filter and a filter-enable bit. A configure command either clears and arms the target counter or freezes it at its current value. A read command copies the target counter into a snapshot register together with an invalid flag. A busy flag is raised for the cycle in which a command executes. Commands presented while busy is high are dropped.

Top module: `cap_occ_monitor`

## Requirements
- R1: An armed counter adds `alloc_units` when `alloc_vld` hits it and subtracts `free_units` when `free_vld` hits it. When both hit in the same cycle, the net of the two is applied, then clamped. The result appears on the clock edge that samples the strobes.
- R2: A counter never goes below zero. A release that would make it negative leaves it at 0, including the case of a same-cycle allocation that is smaller than the release.
- R3: A counter saturates at 2^CNT_W-1 and holds that value while further allocations arrive. A later release lowers it from that maximum.
- R4: A configure command (`ctl_op`=1) with `ctl_evt`=1 (occupancy) clears the target counter to 0, arms it, latches its filter and marks it valid. Counters of other identifiers are not disturbed.
- R5: With the latched filter-enable at 0, an armed counter tracks every access type and ignores the filter value. With it at 1, only requests whose `*_at` equals the latched filter are tracked.
- R6: A configure command with `ctl_evt`=0 stops the counter. The counter keeps its current value and ignores all later strobes until it is re-armed.
- R7: A configure command with any `ctl_evt` other than 0 or 1 leaves the target's value, arming and filter unchanged. Any `ctl_op` other than 1 or 2, including the custom range 24..31, likewise changes nothing.
- R8: `ctl_busy` is 0 after reset. A `ctl_wr` seen while `ctl_busy` is 0 makes `ctl_busy` 1 for exactly the next cycle, and the command executes at the end of that cycle. A `ctl_wr` seen while `ctl_busy` is 1 is ignored.
- R9: A read command (`ctl_op`=2) loads `snap_count` with the target counter and `snap_inv` with 0 if the counter has been armed since reset, 1 otherwise. After reset `snap_count` is 0 and `snap_inv` is 1. The snapshot changes only on a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocation strobe |
| alloc_mcid | input | ID_W | Identifier of the allocating request |
| alloc_at | input | AT_W | Access type of the allocating request |
| alloc_units | input | UNIT_W | Capacity units allocated |
| free_vld | input | 1 | Release strobe |
| free_mcid | input | ID_W | Identifier charged with the release |
| free_at | input | AT_W | Access type of the release |
| free_units | input | UNIT_W | Capacity units released |
| ctl_wr | input | 1 | Command write strobe |
| ctl_op | input | 5 | Operation: 1 configure, 2 read, others no effect |
| ctl_at | input | AT_W | Access-type filter value |
| ctl_atv | input | 1 | Access-type filter enable |
| ctl_mcid | input | ID_W | Target identifier |
| ctl_evt | input | 8 | Event selector: 0 stop, 1 occupancy, others ignored |
| ctl_busy | output | 1 | Command in execution |
| snap_count | output | CNT_W | Snapshot of the last counter read |
| snap_inv | output | 1 | Snapshot invalid flag |

## Verification
The main test is a sweep of 160 event cycles over all eight counters. Some counters filter on access type and some track every type. The sweep mixes lone allocations, lone releases and same-cycle pairs on the same and on different identifiers. A reference model predicts every counter, and all eight counters are read back after each step. A mistake in the net-then-clamp order therefore shows up apart from a mistake in filter decoding or in identifier selection. Directed patterns then cover the remaining cases:
- releasing more than is held, which separates clamping from wrap-around;
- a run of allocations long enough to reach the maximum;
- freezing and re-arming a counter, and commands that must be dropped, which separates state left alone from state that was cleared.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int OP_W  = 5;
  localparam int EVT_W = 8;

  localparam logic [OP_W-1:0]  OP_CFG_EVENT = 5'd1;
  localparam logic [OP_W-1:0]  OP_READ_CNT  = 5'd2;

  localparam logic [EVT_W-1:0] EVT_STOP = 8'd0;
  localparam logic [EVT_W-1:0] EVT_OCC  = 8'd1;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [EVT_W-1:0] evt;
    logic             atv;
  } occ_cmd_t;
endpackage

// File: rtl/occ_ctl.sv
module occ_ctl
  import occ_pkg::*;
#(
  parameter int ID_W = 3,
  parameter int AT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OP_W-1:0]  op,
  input  logic [EVT_W-1:0] evt,
  input  logic             atv,
  input  logic [AT_W-1:0]  at,
  input  logic [ID_W-1:0]  id,
  output logic             busy,
  output logic             exec_cfg,
  output logic             exec_rd,
  output logic [ID_W-1:0]  x_id,
  output logic [AT_W-1:0]  x_at,
  output logic             x_atv,
  output logic [EVT_W-1:0] x_evt
);
  occ_cmd_t cmd_q;
  logic [ID_W-1:0] id_q;
  logic [AT_W-1:0] at_q;
  logic busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
      id_q   <= '0;
      at_q   <= '0;
    end else if (wr && !busy_q) begin
      busy_q    <= 1'b1;
      cmd_q.op  <= op;
      cmd_q.evt <= evt;
      cmd_q.atv <= atv;
      id_q      <= id;
      at_q      <= at;
    end else begin
      busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign exec_cfg = busy_q && (cmd_q.op == OP_CFG_EVENT);
  assign exec_rd  = busy_q && (cmd_q.op == OP_READ_CNT);
  assign x_id     = id_q;
  assign x_at     = at_q;
  assign x_atv    = cmd_q.atv;
  assign x_evt    = cmd_q.evt;

  // R8
  wr_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && !busy_q) |=> busy_q);
  // R8
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);
endmodule

// File: rtl/occ_cell.sv
module occ_cell
  import occ_pkg::*;
#(
  parameter int MY_ID  = 0,
  parameter int ID_W   = 3,
  parameter int AT_W   = 3,
  parameter int UNIT_W = 8,
  parameter int CNT_W  = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic [EVT_W-1:0] cfg_evt,
  input  logic             cfg_atv,
  input  logic [AT_W-1:0]  cfg_at,
  input  logic             a_vld,
  input  logic [ID_W-1:0]  a_id,
  input  logic [AT_W-1:0]  a_at,
  input  logic [UNIT_W-1:0] a_units,
  input  logic             f_vld,
  input  logic [ID_W-1:0]  f_id,
  input  logic [AT_W-1:0]  f_at,
  input  logic [UNIT_W-1:0] f_units,
  output logic [CNT_W-1:0] count,
  output logic             valid
);
  localparam logic [ID_W-1:0]  SELF = ID_W'(MY_ID);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam int SUM_W = CNT_W + 1;

  logic             active_q, valid_q, atv_q;
  logic [AT_W-1:0]  at_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             a_hit, f_hit;
  logic [SUM_W-1:0] up, inc, dec, diff;

  always_comb begin
    a_hit = a_vld && (a_id == SELF) && (!atv_q || (a_at == at_q));
    f_hit = f_vld && (f_id == SELF) && (!atv_q || (f_at == at_q));
    inc   = a_hit ? SUM_W'(a_units) : '0;
    dec   = f_hit ? SUM_W'(f_units) : '0;
    up    = SUM_W'(cnt_q) + inc;
    diff  = up - dec;
    if (dec >= up)
      cnt_nxt = '0;
    else if (diff > SUM_W'(MAXV))
      cnt_nxt = MAXV;
    else
      cnt_nxt = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      atv_q    <= 1'b0;
      at_q     <= '0;
      cnt_q    <= '0;
    end else if (cfg_en) begin
      if (cfg_evt == EVT_OCC) begin
        cnt_q    <= '0;
        active_q <= 1'b1;
        valid_q  <= 1'b1;
        atv_q    <= cfg_atv;
        at_q     <= cfg_atv ? cfg_at : '0;
      end else if (cfg_evt == EVT_STOP) begin
        active_q <= 1'b0;
      end
    end else if (active_q) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign count = cnt_q;
  assign valid = valid_q;

  // R4
  arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_evt == EVT_OCC) |=> (cnt_q == '0 && active_q));
  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !cfg_en) |=> $stable(cnt_q));
  // R2
  zero_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !cfg_en && cnt_q == '0 && !a_hit && f_hit) |=> (cnt_q == '0));
  // R3
  max_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active_q && !cfg_en && cnt_q == MAXV && a_hit && !f_hit) |=> (cnt_q == MAXV));
endmodule

// File: rtl/occ_snap.sv
module occ_snap #(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3,
  parameter int CNT_W   = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_en,
  input  logic [ID_W-1:0]          rd_id,
  input  logic [NUM_IDS*CNT_W-1:0] cnt_flat,
  input  logic [NUM_IDS-1:0]       valid_vec,
  output logic [CNT_W-1:0]         snap_count,
  output logic                     snap_inv
);
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_count <= '0;
      snap_inv   <= 1'b1;
    end else if (rd_en) begin
      snap_count <= cnt_flat[rd_id*CNT_W +: CNT_W];
      snap_inv   <= !valid_vec[rd_id];
    end
  end

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(snap_count) && $stable(snap_inv)));
endmodule

// File: rtl/cap_occ_monitor.sv
module cap_occ_monitor
  import occ_pkg::*;
#(
  parameter int NUM_IDS = 8,
  parameter int AT_W    = 3,
  parameter int UNIT_W  = 8,
  parameter int CNT_W   = 20,
  localparam int ID_W   = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_vld,
  input  logic [ID_W-1:0]   alloc_mcid,
  input  logic [AT_W-1:0]   alloc_at,
  input  logic [UNIT_W-1:0] alloc_units,
  input  logic              free_vld,
  input  logic [ID_W-1:0]   free_mcid,
  input  logic [AT_W-1:0]   free_at,
  input  logic [UNIT_W-1:0] free_units,
  input  logic              ctl_wr,
  input  logic [4:0]        ctl_op,
  input  logic [AT_W-1:0]   ctl_at,
  input  logic              ctl_atv,
  input  logic [ID_W-1:0]   ctl_mcid,
  input  logic [7:0]        ctl_evt,
  output logic              ctl_busy,
  output logic [CNT_W-1:0]  snap_count,
  output logic              snap_inv
);
  logic             exec_cfg, exec_rd, x_atv;
  logic [ID_W-1:0]  x_id;
  logic [AT_W-1:0]  x_at;
  logic [EVT_W-1:0] x_evt;
  logic [NUM_IDS*CNT_W-1:0] cnt_flat;
  logic [NUM_IDS-1:0]       valid_vec;

  occ_ctl #(.ID_W(ID_W), .AT_W(AT_W)) u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .op(ctl_op), .evt(ctl_evt),
    .atv(ctl_atv), .at(ctl_at), .id(ctl_mcid), .busy(ctl_busy),
    .exec_cfg(exec_cfg), .exec_rd(exec_rd), .x_id(x_id), .x_at(x_at),
    .x_atv(x_atv), .x_evt(x_evt)
  );

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_cell
    occ_cell #(
      .MY_ID(g), .ID_W(ID_W), .AT_W(AT_W), .UNIT_W(UNIT_W), .CNT_W(CNT_W)
    ) u_cell (
      .clk(clk), .rst(rst),
      .cfg_en(exec_cfg && (x_id == ID_W'(g))),
      .cfg_evt(x_evt), .cfg_atv(x_atv), .cfg_at(x_at),
      .a_vld(alloc_vld), .a_id(alloc_mcid), .a_at(alloc_at), .a_units(alloc_units),
      .f_vld(free_vld), .f_id(free_mcid), .f_at(free_at), .f_units(free_units),
      .count(cnt_flat[g*CNT_W +: CNT_W]), .valid(valid_vec[g])
    );
  end

  occ_snap #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst(rst), .rd_en(exec_rd), .rd_id(x_id),
    .cnt_flat(cnt_flat), .valid_vec(valid_vec),
    .snap_count(snap_count), .snap_inv(snap_inv)
  );
endmodule

// File: tb/test_cap_occ_monitor.sv
module test_cap_occ_monitor;
  localparam int N    = 8;
  localparam int CW   = 20;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst = 1;
  logic alloc_vld = 0, free_vld = 0, ctl_wr = 0, ctl_atv = 0;
  logic [2:0] alloc_mcid = 0, alloc_at = 0, free_mcid = 0, free_at = 0, ctl_at = 0, ctl_mcid = 0;
  logic [7:0] alloc_units = 0, free_units = 0, ctl_evt = 0;
  logic [4:0] ctl_op = 0;
  logic ctl_busy, snap_inv;
  logic [CW-1:0] snap_count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_cnt[N];
  bit m_act[N], m_val[N], m_atv[N];
  int m_at[N];

  always #10 clk = ~clk;

  cap_occ_monitor i_cap_occ_monitor (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_mcid(alloc_mcid),
    .alloc_at(alloc_at), .alloc_units(alloc_units), .free_vld(free_vld),
    .free_mcid(free_mcid), .free_at(free_at), .free_units(free_units),
    .ctl_wr(ctl_wr), .ctl_op(ctl_op), .ctl_at(ctl_at), .ctl_atv(ctl_atv),
    .ctl_mcid(ctl_mcid), .ctl_evt(ctl_evt), .ctl_busy(ctl_busy),
    .snap_count(snap_count), .snap_inv(snap_inv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_cfg(int op, int id, int at, bit atv, int evt);
    if (op == 1) begin
      if (evt == 1) begin
        m_cnt[id] = 0; m_act[id] = 1; m_val[id] = 1;
        m_atv[id] = atv; m_at[id] = atv ? at : 0;
      end else if (evt == 0) m_act[id] = 0;
    end
  endfunction

  task automatic cmd(int op, int id, int at, bit atv, int evt);
    ctl_wr = 1; ctl_op = 5'(op); ctl_mcid = 3'(id); ctl_at = 3'(at);
    ctl_atv = atv; ctl_evt = 8'(evt);
    @(posedge clk); @(negedge clk);
    ctl_wr = 0;
    check(ctl_busy == 1, "R8 busy set", int'(ctl_busy), 1);
    @(posedge clk); @(negedge clk);
    check(ctl_busy == 0, "R8 busy clear", int'(ctl_busy), 0);
    model_cfg(op, id, at, atv, evt);
  endtask

  task automatic rd(int id, string req);
    cmd(2, id, 0, 0, 0);
    check(int'(snap_count) == m_cnt[id], req, int'(snap_count), m_cnt[id]);
    check(snap_inv == !m_val[id], {req, " inv"}, int'(snap_inv), int'(!m_val[id]));
  endtask

  function automatic void model_ev(bit av, int aid, int aat, int au, bit fv, int fid, int fat, int fu);
    for (int i = 0; i < N; i++) begin
      int inc = 0, dec = 0, nv;
      if (!m_act[i]) continue;
      if (av && aid == i && (!m_atv[i] || aat == m_at[i])) inc = au;
      if (fv && fid == i && (!m_atv[i] || fat == m_at[i])) dec = fu;
      nv = m_cnt[i] + inc - dec;
      if (nv < 0) nv = 0;
      if (nv > MAXC) nv = MAXC;
      m_cnt[i] = nv;
    end
  endfunction

  task automatic ev(bit av, int aid, int aat, int au, bit fv, int fid, int fat, int fu);
    alloc_vld = av; alloc_mcid = 3'(aid); alloc_at = 3'(aat); alloc_units = 8'(au);
    free_vld = fv; free_mcid = 3'(fid); free_at = 3'(fat); free_units = 8'(fu);
    @(posedge clk); @(negedge clk);
    alloc_vld = 0; free_vld = 0;
    model_ev(av, aid, aat, au, fv, fid, fat, fu);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_cnt[i] = 0; m_act[i] = 0; m_val[i] = 0; m_atv[i] = 0; m_at[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(ctl_busy == 0, "R8 reset busy", int'(ctl_busy), 0);
    check(snap_inv == 1, "R9 reset inv", int'(snap_inv), 1);
    check(snap_count == 0, "R9 reset count", int'(snap_count), 0);
    rd(3, "R9 unarmed read");

    // R4: arm all counters; odd ids filter on at = id%4
    for (int i = 0; i < N; i++) cmd(1, i, i % 4, i[0], 1);
    for (int i = 0; i < N; i++) rd(i, "R4 armed zero");

    // R1 R2 R5 sweep
    for (int k = 0; k < 160; k++) begin
      int aid = (k * 3) % 8;
      int fid = (k % 5 == 0) ? aid : (k * 5 + 1) % 8;
      ev((k % 3) != 2, aid, (k * 5 + k / 7) % 8, (k * 7) % 16 + 1,
         (k % 4) != 0, fid, (k / 2) % 8, (k * 11) % 24);
      for (int i = 0; i < N; i++) rd(i, "R1 R2 R5 sweep");
    end

    // R2 directed on id 2 (filter off)
    cmd(1, 2, 0, 0, 1);
    ev(1, 2, 6, 5, 0, 0, 0, 0);
    ev(0, 0, 0, 0, 1, 2, 3, 9);
    rd(2, "R2 over-release");
    ev(1, 2, 1, 3, 1, 2, 4, 10);
    rd(2, "R2 same-cycle floor");
    ev(1, 2, 1, 10, 1, 2, 4, 3);
    rd(2, "R1 same-cycle net");

    // R5 directed on id 1 (filter at=1)
    cmd(1, 1, 1, 1, 1);
    ev(1, 1, 2, 6, 0, 0, 0, 0);
    rd(1, "R5 mismatched at");
    ev(1, 1, 1, 6, 0, 0, 0, 0);
    rd(1, "R5 matched at");

    // R6 freeze and re-arm
    cmd(1, 2, 0, 0, 0);
    ev(1, 2, 0, 4, 0, 0, 0, 0);
    rd(2, "R6 frozen keeps");
    cmd(1, 2, 0, 0, 1);
    rd(2, "R4 re-arm clears");

    // R7 ignored commands on id 4
    cmd(1, 4, 0, 0, 1);
    ev(1, 4, 0, 12, 0, 0, 0, 0);
    cmd(1, 4, 0, 0, 5);
    rd(4, "R7 illegal evt");
    ev(1, 4, 0, 3, 0, 0, 0, 0);
    rd(4, "R7 still armed");
    cmd(7, 4, 0, 0, 1);
    rd(4, "R7 op 7");
    cmd(24, 4, 0, 0, 1);
    rd(4, "R7 op 24");

    // R8 write during busy is dropped
    cmd(1, 6, 0, 0, 1);
    ev(1, 6, 0, 9, 0, 0, 0, 0);
    ctl_wr = 1; ctl_op = 5'd1; ctl_mcid = 3'd6; ctl_evt = 8'd0; ctl_atv = 0;
    @(posedge clk); @(negedge clk);
    ctl_evt = 8'd1;
    @(posedge clk); @(negedge clk);
    ctl_wr = 0;
    check(ctl_busy == 0, "R8 no second busy", int'(ctl_busy), 0);
    model_cfg(1, 6, 0, 0, 0);
    ev(1, 6, 0, 4, 0, 0, 0, 0);
    rd(6, "R8 busy write ignored");

    // R3 saturation on id 5
    cmd(1, 5, 0, 0, 1);
    alloc_vld = 1; alloc_mcid = 3'd5; alloc_at = 0; alloc_units = 8'd255;
    for (int k = 0; k < 4200; k++) begin
      @(posedge clk);
      model_ev(1, 5, 0, 255, 0, 0, 0, 0);
    end
    @(negedge clk);
    alloc_vld = 0;
    rd(5, "R3 saturate");
    ev(1, 5, 0, 200, 0, 0, 0, 0);
    rd(5, "R3 hold at max");
    ev(0, 0, 0, 0, 1, 5, 0, 1);
    rd(5, "R3 release from max");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule